// File: doc/BRIEF.md
# Turn-Taking Shared-Data-Line SPI Endpoint

This block is the device-side end of a serial link in which the host and the device take turns acting as SPI master over a single bidirectional data line. MISO is not used. The host always opens an exchange as master and clocks a command byte in. The block receives that byte in slave mode and presents it on a parallel output with a one-cycle strobe.

When the device logic has a response byte, it hands the byte over with a start pulse. The block then waits until the bus has been quiet for a programmable number of cycles. After that it takes mastership: it drives SCK, the active-low select and the data line, and shifts the byte out MSB first. It then releases all three drivers and returns to idling as a slave. The device logic may raise the start at any time, so however long it takes to prepare a response is absorbed naturally.

All pad inputs are brought into the system clock domain through synchronizers. SCK is generated from the system clock by a half-period divider.

Top module: `tt_spi_endpoint`

## Requirements
- R1: After reset all three output enables are low, `rx_valid` is low, `tx_busy` is low and `tx_done` is low.
- R2: In slave mode the block samples the data line on each rising SCK edge while select is low. It assembles bits MSB first and pulses `rx_valid` for exactly one cycle after the eighth rising edge of a frame, with the assembled byte on `rx_data`.
- R3: If select rises before eight rising edges have been seen, the partial byte is discarded: no strobe is raised, and the next frame starts again from its first bit.
- R4: While the device is not master, its SCK, select and data drivers are all released. While it is master, all three are driven.
- R5: As master the block sends the byte MSB first with exactly eight SCK pulses. The data line changes only while SCK is low, that is at falling edges, and never during a high phase.
- R6: As master, SCK is low when select is driven low and when select is returned high. Select stays low from before the first rising edge until after the last falling edge.
- R7: After a start, the block takes mastership only once it has seen select high and SCK low for `IDLE_MIN` consecutive synchronized cycles. While the host holds select low, the block waits without limit and drives nothing.
- R8: `tx_busy` is high from the cycle after an accepted start until the drivers are released. `tx_done` pulses for one cycle in the first cycle after release. A start raised while `tx_busy` is high is ignored.
- R9: SCK edges produced by the device's own transmission never produce an `rx_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SCK pad input |
| sck_o | output | 1 | SCK value driven when master |
| sck_oe | output | 1 | SCK driver enable |
| ss_n_i | input | 1 | Select pad input, active low |
| ss_n_o | output | 1 | Select value driven when master |
| ss_n_oe | output | 1 | Select driver enable |
| sd_i | input | 1 | Shared data pad input |
| sd_o | output | 1 | Data value driven when master |
| sd_oe | output | 1 | Data driver enable |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a complete received byte |
| tx_data | input | 8 | Response byte, captured on an accepted start |
| tx_start | input | 1 | Request to transmit `tx_data` |
| tx_busy | output | 1 | Transmission pending or in progress |
| tx_done | output | 1 | One-cycle pulse after the drivers are released |

## Verification
The assertions check the following on every cycle:
- the data line holds steady through each high SCK phase while mastering;
- select only changes while SCK is low;
- the receive strobe never lasts two cycles and never appears while the device drives the bus;
- mastership begins only with select seen high;
- the done pulse follows a busy period.

Several properties can only be shown by the bench scenarios:
- the bit order and edge count of whole bytes in both directions;
- the discarding of partial frames of every length;
- the unlimited wait while the host holds the bus, and the measured quiet gap before takeover;
- the ignoring of a start raised during a transmission.

// File: rtl/tt_spi_pkg.sv
package tt_spi_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_WAIT,
    TX_SETUP,
    TX_HIGH,
    TX_LOW,
    TX_HOLD,
    TX_END
  } tx_state_e;
endpackage

// File: rtl/tt_spi_sync.sv
module tt_spi_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tt_spi_rx.sv
module tt_spi_rx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            sck_s,
  input  logic            ss_n_s,
  input  logic            sd_s,
  output logic [BITS-1:0] rx_data,
  output logic            rx_valid
);
  localparam int CW = $clog2(BITS);

  logic            sck_prev_q;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BITS-1:0] sh_q, sh_d;
  logic [BITS-1:0] data_q, data_d;
  logic            valid_q, valid_d;
  logic            rise;

  assign rise = sck_s & ~sck_prev_q & ~ss_n_s & en;

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    data_d  = data_q;
    valid_d = 1'b0;
    if (ss_n_s || !en) begin
      cnt_d = '0;
    end else if (rise) begin
      sh_d  = {sh_q[BITS-2:0], sd_s};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(BITS-1)) begin
        data_d  = {sh_q[BITS-2:0], sd_s};
        valid_d = 1'b1;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      data_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      data_q     <= data_d;
      valid_q    <= valid_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;

  // R2: a byte needs eight edges, so the strobe can never repeat back to back
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/tt_spi_tx.sv
module tt_spi_tx
  import tt_spi_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int HALF_CYC = 4,
  parameter int IDLE_MIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_s,
  input  logic            ss_n_s,
  input  logic [BITS-1:0] tx_data,
  input  logic            tx_start,
  output logic            drive,
  output logic            sck_o,
  output logic            ss_n_o,
  output logic            sd_o,
  output logic            tx_busy,
  output logic            tx_done
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int IW = $clog2(IDLE_MIN + 1);
  localparam int BW = $clog2(BITS);

  tx_state_e       state_q, state_d;
  logic [TW-1:0]   timer_q, timer_d;
  logic [IW-1:0]   idle_q, idle_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic [BITS-1:0] sh_q, sh_d;
  logic            done_q, done_d;
  logic            tick;
  logic            timed;

  assign tick  = (timer_q == TW'(HALF_CYC - 1));
  assign timed = (state_q != TX_IDLE) && (state_q != TX_WAIT);

  always_comb begin
    state_d = state_q;
    timer_d = timed ? (tick ? '0 : timer_q + 1'b1) : '0;
    idle_d  = idle_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    done_d  = 1'b0;
    unique case (state_q)
      TX_IDLE: if (tx_start) begin
        sh_d    = tx_data;
        idle_d  = '0;
        state_d = TX_WAIT;
      end
      TX_WAIT: begin
        if (ss_n_s && !sck_s) begin
          if (idle_q == IW'(IDLE_MIN - 1)) begin
            bit_d   = '0;
            state_d = TX_SETUP;
          end else begin
            idle_d = idle_q + 1'b1;
          end
        end else begin
          idle_d = '0;
        end
      end
      TX_SETUP: if (tick) state_d = TX_HIGH;
      TX_HIGH: if (tick) begin
        if (bit_q == BW'(BITS - 1)) begin
          state_d = TX_HOLD;
        end else begin
          sh_d    = {sh_q[BITS-2:0], 1'b0};
          bit_d   = bit_q + 1'b1;
          state_d = TX_LOW;
        end
      end
      TX_LOW:  if (tick) state_d = TX_HIGH;
      TX_HOLD: if (tick) state_d = TX_END;
      TX_END: if (tick) begin
        done_d  = 1'b1;
        state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      timer_q <= '0;
      idle_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
      idle_q  <= idle_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      done_q  <= done_d;
    end
  end

  assign drive   = timed;
  assign sck_o   = (state_q == TX_HIGH);
  assign ss_n_o  = !((state_q == TX_SETUP) || (state_q == TX_HIGH) ||
                     (state_q == TX_LOW)   || (state_q == TX_HOLD));
  assign sd_o    = sh_q[BITS-1];
  assign tx_busy = (state_q != TX_IDLE);
  assign tx_done = done_q;

  // R5: data held through every high SCK phase
  p_data_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && sck_o && $past(sck_o)) |-> $stable(sd_o));
  // R6: select only moves while SCK is low
  p_ss_edge_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && $changed(ss_n_o)) |-> (!sck_o && !$past(sck_o)));
  // R7: mastership begins only after the line was seen free
  p_take_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(ss_n_s && !sck_s));
  // R8: done follows a busy period and lands with busy low
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_busy && $past(tx_busy)));
endmodule

// File: rtl/tt_spi_endpoint.sv
module tt_spi_endpoint #(
  parameter int BITS     = 8,
  parameter int SYNC     = 2,
  parameter int HALF_CYC = 4,
  parameter int IDLE_MIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            ss_n_i,
  output logic            ss_n_o,
  output logic            ss_n_oe,
  input  logic            sd_i,
  output logic            sd_o,
  output logic            sd_oe,
  output logic [BITS-1:0] rx_data,
  output logic            rx_valid,
  input  logic [BITS-1:0] tx_data,
  input  logic            tx_start,
  output logic            tx_busy,
  output logic            tx_done
);
  logic [2:0] pads_s;
  logic       drive;

  tt_spi_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sck_i, ss_n_i, sd_i}),
    .q    (pads_s)
  );

  tt_spi_rx #(.BITS(BITS)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (!drive),
    .sck_s   (pads_s[2]),
    .ss_n_s  (pads_s[1]),
    .sd_s    (pads_s[0]),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

  tt_spi_tx #(.BITS(BITS), .HALF_CYC(HALF_CYC), .IDLE_MIN(IDLE_MIN)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (pads_s[2]),
    .ss_n_s  (pads_s[1]),
    .tx_data (tx_data),
    .tx_start(tx_start),
    .drive   (drive),
    .sck_o   (sck_o),
    .ss_n_o  (ss_n_o),
    .sd_o    (sd_o),
    .tx_busy (tx_busy),
    .tx_done (tx_done)
  );

  assign sck_oe  = drive;
  assign ss_n_oe = drive;
  assign sd_oe   = drive;

  // R9: own transmission never yields a receive strobe
  p_no_self_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> !rx_valid);
  // R4: drivers only on while a transmission is pending
  p_drive_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck_oe |-> tx_busy);
endmodule

// File: tb/tt_spi_endpoint_bench.sv
module tt_spi_endpoint_bench;
  localparam int H        = 6;
  localparam int IDLE_MIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic h_oe = 1'b0, h_sck = 1'b0, h_ss = 1'b1, h_sd = 1'b0;
  logic sck_o, sck_oe, ss_n_o, ss_n_oe, sd_o, sd_oe;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic rx_valid, tx_start = 1'b0, tx_busy, tx_done;
  logic sck_line, ss_line, sd_line;

  assign sck_line = sck_oe  ? sck_o  : (h_oe ? h_sck : 1'b0);
  assign ss_line  = ss_n_oe ? ss_n_o : (h_oe ? h_ss  : 1'b1);
  assign sd_line  = sd_oe   ? sd_o   : (h_oe ? h_sd  : 1'b0);

  tt_spi_endpoint #(.IDLE_MIN(IDLE_MIN)) u_tt_spi_endpoint (
    .clk(clk), .rst_n(rst_n),
    .sck_i(sck_line), .sck_o(sck_o), .sck_oe(sck_oe),
    .ss_n_i(ss_line), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe),
    .sd_i(sd_line), .sd_o(sd_o), .sd_oe(sd_oe),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_start(tx_start),
    .tx_busy(tx_busy), .tx_done(tx_done)
  );

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitors sampled at the falling clock edge
  int rx_count = 0, frames = 0, bad_order = 0, contention = 0, hi_change = 0;
  int mon_bits = 0, last_bits = 0;
  logic [7:0] last_rx = 0, mon_byte = 0, last_byte = 0;
  logic sck_p = 1'b0, ss_p = 1'b1, sd_p = 1'b0;
  always @(negedge clk) begin
    if (rx_valid) begin rx_count++; last_rx = rx_data; end
    if (h_oe && (sck_oe || ss_n_oe || sd_oe)) contention++;
    if (sck_oe) begin
      if (!ss_line && sck_line && !sck_p) begin
        mon_byte = {mon_byte[6:0], sd_line};
        mon_bits++;
      end
      if (sck_line && sck_p && sd_line != sd_p) hi_change++;
      if (ss_p && !ss_line) begin
        if (sck_line) bad_order++;
        mon_bits = 0;
      end
      if (!ss_p && ss_line) begin
        if (sck_line) bad_order++;
        frames++; last_byte = mon_byte; last_bits = mon_bits;
      end
    end
    sck_p = sck_line; ss_p = ss_line; sd_p = sd_line;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_send(input logic [7:0] b, input int nbits);
    @(negedge clk);
    h_oe = 1'b1; h_sck = 1'b0; h_ss = 1'b1;
    wait_cyc(H);
    h_ss = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      h_sd = b[7-i];
      wait_cyc(H);
      h_sck = 1'b1;
      wait_cyc(H);
      h_sck = 1'b0;
    end
    wait_cyc(H);
    h_ss = 1'b1;
    wait_cyc(H);
    h_oe = 1'b0;
    wait_cyc(4);
  endtask

  task automatic pulse_start(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!tx_done && waited < 2000) begin @(negedge clk); waited++; end
  endtask

  initial begin
    int w, f0, r0, gap;
    wait_cyc(3);
    // R1 reset state
    check(!sck_oe && !ss_n_oe && !sd_oe, "R1 drivers", int'(sck_oe), 0);
    check(!rx_valid && !tx_busy && !tx_done, "R1 status", int'(tx_busy), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    check(!sck_oe && !tx_busy, "R1 after release", int'(sck_oe), 0);

    // R2 every byte value received, R4 no driving while slave
    for (int b = 0; b < 256; b++) begin
      r0 = rx_count;
      host_send(8'(b), 8);
      check(rx_count == r0 + 1, "R2 one strobe", rx_count - r0, 1);
      check(last_rx == 8'(b), "R2 data", int'(last_rx), b);
    end
    check(contention == 0, "R4 released while slave", contention, 0);

    // R3 partial frames of every length discarded
    for (int n = 1; n < 8; n++) begin
      r0 = rx_count;
      host_send(8'hFF, n);
      check(rx_count == r0, "R3 no strobe", rx_count - r0, 0);
      host_send(8'(8'h3C ^ n), 8);
      check(rx_count == r0 + 1 && last_rx == 8'(8'h3C ^ n), "R3 restart",
            int'(last_rx), int'(8'h3C ^ n));
    end

    // R5 R6 R8 R9 every byte value transmitted
    for (int b = 0; b < 256; b++) begin
      f0 = frames; r0 = rx_count;
      pulse_start(8'(b));
      check(tx_busy, "R8 busy after start", int'(tx_busy), 1);
      wait_done(w);
      check(w < 2000, "R8 done seen", w, 0);
      @(negedge clk);
      check(!tx_busy && !sck_oe && !ss_n_oe && !sd_oe, "R4 released after",
            int'(sck_oe), 0);
      check(frames == f0 + 1, "R5 one frame", frames - f0, 1);
      check(last_bits == 8, "R5 eight edges", last_bits, 8);
      check(last_byte == 8'(b), "R5 byte", int'(last_byte), b);
      check(rx_count == r0, "R9 no self strobe", rx_count - r0, 0);
    end
    check(bad_order == 0, "R6 select with SCK low", bad_order, 0);
    check(hi_change == 0, "R5 data stable while high", hi_change, 0);

    // R7 host holds select: device waits, then honours the quiet gap
    @(negedge clk);
    h_oe = 1'b1; h_sck = 1'b0; h_ss = 1'b0;
    f0 = frames;
    pulse_start(8'hA5);
    wait_cyc(300);
    check(!sck_oe && !ss_n_oe && tx_busy, "R7 waits for host", int'(ss_n_oe), 0);
    h_ss = 1'b1;
    @(negedge clk);
    h_oe = 1'b0;
    gap = 1;
    while (!ss_n_oe && gap < 100) begin @(negedge clk); gap++; end
    check(gap >= IDLE_MIN && gap <= IDLE_MIN + 6, "R7 quiet gap", gap, IDLE_MIN + 3);
    wait_done(w);
    wait_cyc(2);
    check(last_byte == 8'hA5 && frames == f0 + 1, "R7 frame after wait",
          int'(last_byte), 8'hA5);

    // R8 a start during a transmission is ignored
    f0 = frames;
    pulse_start(8'h5A);
    wait_cyc(20);
    pulse_start(8'hC3);
    wait_done(w);
    wait_cyc(200);
    check(frames == f0 + 1, "R8 second start ignored", frames - f0, 1);
    check(last_byte == 8'h5A, "R8 first byte kept", int'(last_byte), 8'h5A);
    check(!tx_busy && !sck_oe, "R8 idle afterwards", int'(tx_busy), 0);
    check(contention == 0, "R4 no contention", contention, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule